// File: doc/BRIEF.md
# Reference-Counted Pad Clamp Sequencer

This block owns the low-power isolation of a group of I/O pads. Three bits of a control word drive the isolation: a core-supply power-down bit, an early clamp bit and a main clamp bit. Several clients share the pads, and each one brackets its use with an enable request and a disable request. The block counts the active users. Only the first enable releases the pads and only the last disable isolates them again. Every other request moves the count and nothing else.

A release clears the main clamp first, then the early clamp, then the core power-down. An isolate sequence sets the same bits in the opposite order. Each bit change is a read-modify-write of the control word, so the other bits of the word are never touched. Consecutive bit changes are spaced by a settling time of `DELAY_CYC` clock cycles. By default that is 150 µs worth of cycles at `CLK_HZ`. While a sequence runs, `busy` is high and new requests wait. The acknowledge for the request that started the sequence comes only once the final bit has changed.

A disable while no user is registered is flagged as an error and has no other effect. An enable that would overflow the user count is flagged the same way.

Top module: `pad_clamp_seq`

## Requirements
- R1: After synchronous reset, `ctrl_word` equals `RESET_WORD` with bits `POS_MAIN`, `POS_EARLY` and `POS_CORE` forced to 1. The user count is zero, and `busy`, `en_ack`, `dis_ack` and `err` are all 0.
- R2: An enable accepted at a zero count starts a release sequence. The main clamp bit (default bit 24) clears on the accepting edge E0, the early clamp bit (bit 25) clears at E0+DELAY_CYC, and the core power-down bit (bit 26) clears at E0+2·DELAY_CYC. The count becomes 1.
- R3: A disable accepted at a count of one starts an isolate sequence. It sets bit 26 at E0, bit 25 at E0+DELAY_CYC and bit 24 at E0+2·DELAY_CYC. The count becomes 0.
- R4: An enable accepted at a count that is neither zero nor full increments the count. It changes no bit, does not raise `busy`, and raises `en_ack` in the cycle after the accepting edge.
- R5: A disable accepted at a count above one decrements the count. It changes no bit, does not raise `busy`, and raises `dis_ack` in the cycle after the accepting edge.
- R6: A disable accepted at a zero count raises `err` together with `dis_ack` for one cycle. The word and the count are left unchanged, so a following enable still starts a release sequence.
- R7: `busy` is high from the cycle after E0 through the cycle before the last bit change. During that time no request is accepted. The acknowledge of a sequence is a one-cycle pulse that appears with the last bit change, and a request still held afterwards is accepted two edges later.
- R8: The bits of `ctrl_word` outside the three clamp positions always keep their `RESET_WORD` values. At most one clamp bit changes per clock edge.
- R9: An enable accepted when the count is at its maximum (2^CNT_W−1) raises `err` with `en_ack` and leaves the count and the word unchanged.
- R10: When enable and disable requests are both high in an accepting cycle, the enable is served first, and the disable waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Enable request, held until `en_ack` is seen |
| en_ack | output | 1 | One-cycle acknowledge of an enable |
| dis_req | input | 1 | Disable request, held until `dis_ack` is seen |
| dis_ack | output | 1 | One-cycle acknowledge of a disable |
| ctrl_word | output | WORD_W | Control word holding the three clamp bits |
| clamp_main | output | 1 | Main clamp bit of `ctrl_word` |
| clamp_early | output | 1 | Early clamp bit of `ctrl_word` |
| core_down | output | 1 | Core power-down bit of `ctrl_word` |
| busy | output | 1 | A release or isolate sequence is in progress |
| err | output | 1 | Pulses with the acknowledge of a request that underflows or overflows the count |

## Verification
A plain request has its acknowledge, and any error, visible in the cycle after the accepting edge, with the word unchanged. A sequence shows its first bit change in the cycle after the accepting edge. The next two changes follow exactly DELAY_CYC and 2·DELAY_CYC edges later, and the acknowledge arrives together with the last one. The bench sets each request just after a falling edge and reads every result at the following falling edges. It counts edges from the accepting edge, checks the word is unchanged through each settling window, and checks the bit change on the exact edge. The dropped acknowledge is checked one falling edge after the request is released.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic {PH_IDLE, PH_RUN} phase_e;
  localparam int unsigned N_STEPS = 3;
  typedef logic [1:0] step_t;
endpackage

// File: rtl/pcs_user_count.sv
module pcs_user_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic zero,
  output logic one,
  output logic full
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
  assign one  = (cnt_q == CNT_W'(1));
  assign full = &cnt_q;

  // R9: the count never wraps upward
  a_r9_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    inc |-> !full);
  // R6: the count never wraps downward
  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    dec |-> !zero);
  a_r4_single_move: assert property (@(posedge clk) disable iff (rst)
    !(inc && dec));
endmodule

// File: rtl/pcs_step_timer.sv
module pcs_step_timer #(
  parameter int unsigned DELAY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int unsigned TW = $clog2(DELAY_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TW'(DELAY_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == TW'(1));

  // R2: a settling window is never cut short by a reload
  a_r2_no_early_reload: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt_q == '0 || expire));
endmodule

// File: rtl/pcs_clamp_word.sv
module pcs_clamp_word
  import pcs_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned POS_MAIN   = 24,
  parameter int unsigned POS_EARLY  = 25,
  parameter int unsigned POS_CORE   = 26,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  step_t             step_idx,
  input  logic              apply,
  output logic [WORD_W-1:0] word
);
  localparam logic [WORD_W-1:0] CLAMP_MASK =
    (WORD_W'(1) << POS_MAIN) | (WORD_W'(1) << POS_EARLY) | (WORD_W'(1) << POS_CORE);
  localparam logic [WORD_W-1:0] INIT_WORD = RESET_WORD | CLAMP_MASK;

  logic [WORD_W-1:0] rel_m [N_STEPS];
  logic [WORD_W-1:0] app_m [N_STEPS];
  logic [WORD_W-1:0] touch, setv;
  logic [WORD_W-1:0] word_q;

  // release walks main, early, core; isolate walks the reverse
  for (genvar g = 0; g < N_STEPS; g++) begin : g_step
    localparam int unsigned P_REL = (g == 0) ? POS_MAIN : (g == 1) ? POS_EARLY : POS_CORE;
    localparam int unsigned P_APP = (g == 0) ? POS_CORE : (g == 1) ? POS_EARLY : POS_MAIN;
    assign rel_m[g] = (step_en && !apply && step_idx == step_t'(g)) ? (WORD_W'(1) << P_REL) : '0;
    assign app_m[g] = (step_en &&  apply && step_idx == step_t'(g)) ? (WORD_W'(1) << P_APP) : '0;
  end

  always_comb begin
    touch = '0;
    setv  = '0;
    for (int i = 0; i < N_STEPS; i++) begin
      touch = touch | rel_m[i] | app_m[i];
      setv  = setv | app_m[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= INIT_WORD;
    end else begin
      word_q <= (word_q & ~touch) | setv;
    end
  end

  assign word = word_q;

  // R2: early clamp drops only once the main clamp is already off
  a_r2_release_early_after_main: assert property (@(posedge clk) disable iff (rst)
    $fell(word_q[POS_EARLY]) |-> !word_q[POS_MAIN]);
  a_r2_release_core_after_early: assert property (@(posedge clk) disable iff (rst)
    $fell(word_q[POS_CORE]) |-> !word_q[POS_EARLY]);
  // R3: clamps come back only once the supply is already down
  a_r3_apply_early_after_core: assert property (@(posedge clk) disable iff (rst)
    $rose(word_q[POS_EARLY]) |-> word_q[POS_CORE]);
  a_r3_apply_main_after_early: assert property (@(posedge clk) disable iff (rst)
    $rose(word_q[POS_MAIN]) |-> word_q[POS_EARLY]);
  // R8: one clamp bit per edge
  a_r8_one_bit_per_edge: assert property (@(posedge clk) disable iff (rst)
    $countones(word_q ^ $past(word_q)) <= 1);
endmodule

// File: rtl/pad_clamp_seq.sv
module pad_clamp_seq
  import pcs_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned POS_MAIN   = 24,
  parameter int unsigned POS_EARLY  = 25,
  parameter int unsigned POS_CORE   = 26,
  parameter logic [WORD_W-1:0] RESET_WORD = 32'h0700_0000,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned SETTLE_US  = 150,
  parameter int unsigned DELAY_CYC  = (CLK_HZ / 1000) * SETTLE_US / 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_req,
  output logic              en_ack,
  input  logic              dis_req,
  output logic              dis_ack,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              clamp_main,
  output logic              clamp_early,
  output logic              core_down,
  output logic              busy,
  output logic              err
);
  localparam int unsigned GW = $clog2(DELAY_CYC + 2);

  phase_e phase_q;
  logic   apply_q;
  step_t  step_q;
  logic   en_ack_q, dis_ack_q, err_q;

  logic idle_ok, take_en, take_dis;
  logic zero, one, full;
  logic start_rel, start_app, expire, adv, last;
  logic step_en, apply_sel, tmr_load;
  step_t step_idx;

  // a request is taken only when idle and not in an acknowledge cycle; enable wins a tie
  assign idle_ok  = (phase_q == PH_IDLE) && !en_ack_q && !dis_ack_q;
  assign take_en  = idle_ok && en_req;
  assign take_dis = idle_ok && dis_req && !en_req;

  assign start_rel = take_en && zero;
  assign start_app = take_dis && one;
  assign adv       = (phase_q == PH_RUN) && expire;
  assign last      = adv && (step_q == 2'd1);

  assign step_en   = start_rel || start_app || adv;
  assign step_idx  = adv ? step_q + 2'd1 : 2'd0;
  assign apply_sel = adv ? apply_q : start_app;
  assign tmr_load  = start_rel || start_app || (adv && !last);

  pcs_user_count #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst  (rst),
    .inc  (take_en && !full),
    .dec  (take_dis && !zero),
    .zero (zero),
    .one  (one),
    .full (full)
  );

  pcs_step_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .expire (expire)
  );

  pcs_clamp_word #(
    .WORD_W     (WORD_W),
    .POS_MAIN   (POS_MAIN),
    .POS_EARLY  (POS_EARLY),
    .POS_CORE   (POS_CORE),
    .RESET_WORD (RESET_WORD)
  ) u_word (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .step_idx (step_idx),
    .apply    (apply_sel),
    .word     (ctrl_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      apply_q   <= 1'b0;
      step_q    <= '0;
      en_ack_q  <= 1'b0;
      dis_ack_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      en_ack_q  <= (take_en && !start_rel) || (last && !apply_q);
      dis_ack_q <= (take_dis && !start_app) || (last && apply_q);
      err_q     <= (take_en && full) || (take_dis && zero);
      if (start_rel || start_app) begin
        phase_q <= PH_RUN;
        apply_q <= start_app;
        step_q  <= '0;
      end else if (adv) begin
        step_q <= step_q + 2'd1;
        if (last) phase_q <= PH_IDLE;
      end
    end
  end

  assign en_ack      = en_ack_q;
  assign dis_ack     = dis_ack_q;
  assign err         = err_q;
  assign busy        = (phase_q == PH_RUN);
  assign clamp_main  = ctrl_word[POS_MAIN];
  assign clamp_early = ctrl_word[POS_EARLY];
  assign core_down   = ctrl_word[POS_CORE];

  // spacing monitor: cycles since the word last changed
  logic [WORD_W-1:0] prev_q;
  logic [GW-1:0]     gap_q;
  logic              chg;
  assign chg = (ctrl_word != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= RESET_WORD | (WORD_W'(1) << POS_MAIN) | (WORD_W'(1) << POS_EARLY)
                | (WORD_W'(1) << POS_CORE);
      gap_q  <= '1;
    end else begin
      prev_q <= ctrl_word;
      if (chg)             gap_q <= GW'(1);
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
    end
  end

  // R2 / R3: steps inside a sequence are exactly DELAY_CYC edges apart
  a_r2_step_spacing: assert property (@(posedge clk) disable iff (rst)
    (chg && $past(busy)) |-> (gap_q == GW'(DELAY_CYC)));
  // R7: acknowledges are single-cycle pulses and never overlap a running sequence
  a_r7_en_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    en_ack |=> !en_ack);
  a_r7_dis_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    dis_ack |=> !dis_ack);
  a_r7_no_ack_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!en_ack && !dis_ack));
  // R4 / R5 / R6: outside a sequence the word holds still
  a_r4_idle_word_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(ctrl_word));
  // R6 / R9: an error always rides on an acknowledge
  a_r6_err_with_ack: assert property (@(posedge clk) disable iff (rst)
    err |-> (en_ack || dis_ack));
  // R10: never both acknowledges at once
  a_r10_one_ack: assert property (@(posedge clk) disable iff (rst)
    !(en_ack && dis_ack));
endmodule

// File: tb/sim_pad_clamp_seq.sv
`timescale 1ns/1ps
module sim_pad_clamp_seq;
  localparam int unsigned DLY  = 4;
  localparam int unsigned CW   = 3;
  localparam int unsigned PM   = 24;
  localparam int unsigned PE   = 25;
  localparam int unsigned PC   = 26;
  localparam logic [31:0] RSTW = 32'h5A00_3C81;
  localparam logic [31:0] MASK = (32'h1 << PM) | (32'h1 << PE) | (32'h1 << PC);

  // {is_enable, starts_sequence, expect_err}
  localparam int NV = 10;
  localparam logic [2:0] VEC [NV] = '{
    3'b001, // disable at zero: error (R6)
    3'b110, // first enable: release (R2)
    3'b100, // enable, count 2 (R4)
    3'b100, // enable, count 3 (R4)
    3'b000, // disable, count 2 (R5)
    3'b000, // disable, count 1 (R5)
    3'b010, // last disable: isolate (R3)
    3'b001, // disable at zero again (R6)
    3'b110, // release again (R2)
    3'b010  // isolate again (R3)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_req = 1'b0, dis_req = 1'b0;
  logic en_ack, dis_ack, busy, err;
  logic clamp_main, clamp_early, core_down;
  logic [31:0] ctrl_word;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] wexp;

  always #2.5 clk = ~clk;

  pad_clamp_seq #(
    .WORD_W(32), .POS_MAIN(PM), .POS_EARLY(PE), .POS_CORE(PC),
    .RESET_WORD(RSTW), .CNT_W(CW), .DELAY_CYC(DLY)
  ) u0 (
    .clk(clk), .rst(rst), .en_req(en_req), .en_ack(en_ack),
    .dis_req(dis_req), .dis_ack(dis_ack), .ctrl_word(ctrl_word),
    .clamp_main(clamp_main), .clamp_early(clamp_early), .core_down(core_down),
    .busy(busy), .err(err)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic int unsigned pos_of(input bit apply, input int s);
    if (!apply) return (s == 0) ? PM : (s == 1) ? PE : PC;
    return (s == 0) ? PC : (s == 1) ? PE : PM;
  endfunction

  // called at the falling edge just before the accepting edge
  task automatic watch_seq(input bit apply, input string rq);
    for (int s = 0; s < 3; s++) begin
      if (s > 0) begin
        repeat (DLY - 1) begin
          @(negedge clk);
          chk(rq, "word held in settling window", ctrl_word, wexp);
          chk(rq, "busy in window", {31'd0, busy}, 32'd1);
          chk("R7", "no ack in window", {30'd0, en_ack, dis_ack}, 32'd0);
        end
      end
      @(negedge clk);
      wexp[pos_of(apply, s)] = apply;
      chk(rq, "word after step (R8)", ctrl_word, wexp);
      chk(rq, "own ack", {31'd0, apply ? dis_ack : en_ack}, (s == 2) ? 32'd1 : 32'd0);
      chk("R10", "other ack idle", {31'd0, apply ? en_ack : dis_ack}, 32'd0);
      chk("R7", "busy after step", {31'd0, busy}, (s == 2) ? 32'd0 : 32'd1);
      chk(rq, "err", {31'd0, err}, 32'd0);
    end
  endtask

  task automatic issue(input bit is_en, input bit seq, input bit exp_err);
    string rq;
    rq = seq ? (is_en ? "R2" : "R3") : exp_err ? (is_en ? "R9" : "R6") : (is_en ? "R4" : "R5");
    if (is_en) en_req = 1'b1; else dis_req = 1'b1;
    if (seq) begin
      watch_seq(!is_en, rq);
    end else begin
      @(negedge clk);
      chk(rq, "ack", {31'd0, is_en ? en_ack : dis_ack}, 32'd1);
      chk(rq, "other ack", {31'd0, is_en ? dis_ack : en_ack}, 32'd0);
      chk(rq, "err", {31'd0, err}, {31'd0, exp_err});
      chk(rq, "word unchanged (R8)", ctrl_word, wexp);
      chk(rq, "busy", {31'd0, busy}, 32'd0);
    end
    en_req = 1'b0;
    dis_req = 1'b0;
    @(negedge clk);
    chk("R7", "ack is one cycle", {29'd0, en_ack, dis_ack, err}, 32'd0);
  endtask

  task automatic check_reset_state();
    chk("R1", "reset word", ctrl_word, RSTW | MASK);
    chk("R1", "reset clamp pins", {29'd0, core_down, clamp_early, clamp_main}, 32'd7);
    chk("R1", "reset flags", {28'd0, busy, en_ack, dis_ack, err}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wexp = RSTW | MASK;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    // table walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R9: fill the count, overflow, then drain back to the isolate step
    issue(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < (1 << CW) - 2; i++) issue(1'b1, 1'b0, 1'b0);
    issue(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < (1 << CW) - 2; i++) issue(1'b0, 1'b0, 1'b0);
    issue(1'b0, 1'b1, 1'b0);
    issue(1'b0, 1'b0, 1'b1);

    // R10 and R7: both requests together, disable held through the release
    en_req = 1'b1;
    dis_req = 1'b1;
    watch_seq(1'b0, "R10");
    en_req = 1'b0;
    @(negedge clk);
    chk("R7", "held disable not taken in ack cycle", {30'd0, en_ack, dis_ack}, 32'd0);
    chk("R7", "word still released", ctrl_word, wexp);
    watch_seq(1'b1, "R7");
    dis_req = 1'b0;
    @(negedge clk);
    chk("R7", "ack dropped", {30'd0, en_ack, dis_ack}, 32'd0);

    // R1: reset in the middle of a release
    en_req = 1'b1;
    repeat (DLY + 1) @(negedge clk);
    rst = 1'b1;
    en_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wexp = RSTW | MASK;
    check_reset_state();
    issue(1'b0, 1'b0, 1'b1); // count back at zero (R1)

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule